// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block is the state machine that takes a programmable device from power-on to user mode. It holds the device in a power-on state until the supplies are reported good, captures the boot-mode select pins at that point, and then waits for the boot firmware to finish. It then parks in an idle state until the host requests configuration with a fresh low-to-high edge on its configuration-request pin.

While configuring, the block raises an active-low status output to tell the host that configuration has begun. It accepts abstract done and error flags from the configuration stream and enters user mode on a clean done. A failed stream or a dropped request pin sends it to an error state. The error state drives status low and returns to idle after a programmable hold time, or earlier when the host drops the request pin.

The block also drives per-group weak-pull enables for the configuration I/Os and the general-purpose I/Os, and these change with the state. If the captured boot mode is the JTAG code, the block never leaves startup.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `por_done` is low after reset, `boot_state` stays at code 0 (power-on). On the first clock edge with `por_done` high, it moves to code 1 (startup).
- R2: `mode_latched` takes the value of `mode_sel` on the edge that leaves power-on. It then ignores every later change on `mode_sel` until the next reset.
- R3: When the captured mode equals `JTAG_CODE` (default 3'b111), the state stays at startup (code 1) forever, whatever `fw_done` and `ncfg_in` do.
- R4: For any other captured mode, the edge on which `fw_done` is high in startup moves the state to idle (code 2).
- R5: Idle is left for configuring (code 3) only on an edge where `ncfg_in` is high and was low at the previous edge. A level already high on entry to idle starts nothing.
- R6: `nstatus_out` is high in configuring (code 3) and user (code 4), and low in power-on, startup, idle and error. `cfg_ready` is high only in configuring.
- R7: In configuring, an edge with `cfg_valid` and `cfg_err` high moves to error (code 5), and the error flag wins over done. An edge with `cfg_valid` and `cfg_done` high and `cfg_err` low moves to user (code 4), where `user_mode` is high. The flags are ignored while `cfg_valid` is low.
- R8: `ncfg_in` low on an edge in configuring or user moves the state to error (code 5).
- R9: Error keeps `nstatus_out` low. It lasts `ERR_HOLD` cycles (default 16) and then returns to idle. It returns to idle one edge after a falling `ncfg_in` (high at the previous edge, low now) if that comes first.
- R10: In power-on and startup, the configuration I/O groups at indices 0, 8 and 16 have pull-down enabled and all others have pull-up enabled. From idle on, both enables are off for every configuration group.
- R11: `gpio_pu_en` is all zeros in power-on and in user. It is all ones in startup, idle, configuring and error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_done | input | 1 | Supplies reached operating voltage |
| mode_sel | input | MODE_W | Boot-mode select pins |
| fw_done | input | 1 | Boot firmware finished |
| ncfg_in | input | 1 | Host configuration-request pin |
| cfg_valid | input | 1 | Configuration stream flags are valid |
| cfg_done | input | 1 | Configuration stream completed |
| cfg_err | input | 1 | Configuration stream failed (authentication, decryption or decompression) |
| nstatus_out | output | 1 | Active-low status to the host |
| cfg_ready | output | 1 | Sequencer accepts the configuration stream |
| user_mode | output | 1 | Device is in user mode |
| boot_state | output | 3 | State code: 0 power-on, 1 startup, 2 idle, 3 configuring, 4 user, 5 error |
| mode_latched | output | MODE_W | Boot mode captured at power-on |
| cfg_io_pu_en | output | N_CFG_IO | Weak pull-up enable per configuration I/O group |
| cfg_io_pd_en | output | N_CFG_IO | Pull-down enable per configuration I/O group |
| gpio_pu_en | output | N_GPIO | Weak pull-up enable per general-purpose I/O |

## Verification
Every state change is registered, so it appears in `boot_state` one clock edge after the input that causes it. All status, ready and pull outputs decode the state register with no further delay, so they change on that same edge. The bench drives inputs on the falling edge and reads results at the next falling edge, so exactly one rising edge separates stimulus and check. The error hold is measured by counting the falling edges at which the error code is visible, which must equal `ERR_HOLD`. The boot-mode sweep repeats power-on for all eight select codes.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

  typedef enum logic [2:0] {
    ST_PON     = 3'd0,
    ST_STARTUP = 3'd1,
    ST_IDLE    = 3'd2,
    ST_CONFIG  = 3'd3,
    ST_USER    = 3'd4,
    ST_ERROR   = 3'd5
  } boot_state_e;

  // Status pin level per state: high only once configuration has begun.
  function automatic logic status_level(boot_state_e s);
    return (s == ST_CONFIG) || (s == ST_USER);
  endfunction

  // Configuration I/O pulls are active before firmware hands over.
  function automatic logic cfg_pulls_on(boot_state_e s);
    return (s == ST_PON) || (s == ST_STARTUP);
  endfunction

  // General-purpose pull-ups: on after power-on, released in user mode.
  function automatic logic gpio_pulls_on(boot_state_e s);
    return (s != ST_PON) && (s != ST_USER);
  endfunction

  // Index belongs to the pull-down set: a multiple of stride, within count.
  function automatic logic is_pd_group(int idx, int stride, int count);
    return ((idx % stride) == 0) && ((idx / stride) < count);
  endfunction

endpackage

// File: rtl/cbs_edge_det.sv
module cbs_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic prev_q;

  // Reset to high so a pin held high from power-on never looks like a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= din;
  end

  assign rise = din & ~prev_q;
  assign fall = ~din & prev_q;
endmodule

// File: rtl/cbs_mode_latch.sv
module cbs_mode_latch #(
  parameter int                MODE_W    = 3,
  parameter logic [MODE_W-1:0] JTAG_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [MODE_W-1:0] mode_in,
  output logic [MODE_W-1:0] mode_q,
  output logic              is_jtag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (capture) mode_q <= mode_in;
  end

  assign is_jtag = (mode_q == JTAG_CODE);
endmodule

// File: rtl/cbs_err_timer.sv
module cbs_err_timer #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;
  end

  assign expired = active && (cnt_q == LAST);
endmodule

// File: rtl/cbs_pull_map.sv
module cbs_pull_map
  import cbs_pkg::*;
#(
  parameter int N_CFG_IO  = 24,
  parameter int N_GPIO    = 8,
  parameter int PD_STRIDE = 8,
  parameter int PD_COUNT  = 3
) (
  input  boot_state_e        state,
  output logic [N_CFG_IO-1:0] cfg_pu,
  output logic [N_CFG_IO-1:0] cfg_pd,
  output logic [N_GPIO-1:0]   gpio_pu
);
  logic cfg_on;
  logic gp_on;

  assign cfg_on = cfg_pulls_on(state);
  assign gp_on  = gpio_pulls_on(state);

  for (genvar i = 0; i < N_CFG_IO; i++) begin : g_cfg
    localparam logic IS_PD = is_pd_group(i, PD_STRIDE, PD_COUNT);
    assign cfg_pd[i] = cfg_on &  IS_PD;
    assign cfg_pu[i] = cfg_on & ~IS_PD;
  end

  assign gpio_pu = {N_GPIO{gp_on}};
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cbs_pkg::*;
#(
  parameter int                MODE_W    = 3,
  parameter logic [MODE_W-1:0] JTAG_CODE = 3'b111,
  parameter int                ERR_HOLD  = 16,
  parameter int                N_CFG_IO  = 24,
  parameter int                N_GPIO    = 8,
  parameter int                PD_STRIDE = 8,
  parameter int                PD_COUNT  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                por_done,
  input  logic [MODE_W-1:0]   mode_sel,
  input  logic                fw_done,
  input  logic                ncfg_in,
  input  logic                cfg_valid,
  input  logic                cfg_done,
  input  logic                cfg_err,
  output logic                nstatus_out,
  output logic                cfg_ready,
  output logic                user_mode,
  output logic [2:0]          boot_state,
  output logic [MODE_W-1:0]   mode_latched,
  output logic [N_CFG_IO-1:0] cfg_io_pu_en,
  output logic [N_CFG_IO-1:0] cfg_io_pd_en,
  output logic [N_GPIO-1:0]   gpio_pu_en
);
  boot_state_e state_q, state_d;

  // Named internal events, shared with the checker.
  logic ncfg_rise, ncfg_fall;
  logic mode_capture;
  logic is_jtag;
  logic err_expired;
  logic stream_fail, stream_ok;

  cbs_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ncfg_in),
    .rise (ncfg_rise),
    .fall (ncfg_fall)
  );

  assign mode_capture = (state_q == ST_PON) && por_done;

  cbs_mode_latch #(
    .MODE_W   (MODE_W),
    .JTAG_CODE(JTAG_CODE)
  ) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(mode_capture),
    .mode_in(mode_sel),
    .mode_q (mode_latched),
    .is_jtag(is_jtag)
  );

  cbs_err_timer #(
    .HOLD(ERR_HOLD)
  ) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (state_q == ST_ERROR),
    .expired(err_expired)
  );

  assign stream_fail = cfg_valid && cfg_err;
  assign stream_ok   = cfg_valid && cfg_done && !cfg_err;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PON:     if (por_done) state_d = ST_STARTUP;
      ST_STARTUP: if (!is_jtag && fw_done) state_d = ST_IDLE;
      ST_IDLE:    if (ncfg_rise) state_d = ST_CONFIG;
      ST_CONFIG: begin
        if (!ncfg_in || stream_fail) state_d = ST_ERROR;
        else if (stream_ok)          state_d = ST_USER;
      end
      ST_USER:    if (!ncfg_in) state_d = ST_ERROR;
      ST_ERROR:   if (err_expired || ncfg_fall) state_d = ST_IDLE;
      default:    state_d = ST_PON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PON;
    else        state_q <= state_d;
  end

  assign boot_state  = state_q;
  assign nstatus_out = status_level(state_q);
  assign cfg_ready   = (state_q == ST_CONFIG);
  assign user_mode   = (state_q == ST_USER);

  cbs_pull_map #(
    .N_CFG_IO (N_CFG_IO),
    .N_GPIO   (N_GPIO),
    .PD_STRIDE(PD_STRIDE),
    .PD_COUNT (PD_COUNT)
  ) u_pull (
    .state  (state_q),
    .cfg_pu (cfg_io_pu_en),
    .cfg_pd (cfg_io_pd_en),
    .gpio_pu(gpio_pu_en)
  );
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int MODE_W   = 3,
  parameter int N_CFG_IO = 24,
  parameter int N_GPIO   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ncfg_in,
  input logic                ncfg_rise,
  input logic                is_jtag,
  input logic                nstatus_out,
  input logic                user_mode,
  input logic [2:0]          boot_state,
  input logic [MODE_W-1:0]   mode_latched,
  input logic [N_CFG_IO-1:0] cfg_io_pu_en,
  input logic [N_CFG_IO-1:0] cfg_io_pd_en,
  input logic [N_GPIO-1:0]   gpio_pu_en
);
  // R1: power-on never jumps past startup
  p_pon_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_state == 3'd0) |=> (boot_state == 3'd0 || boot_state == 3'd1));

  // R2: captured mode is frozen once power-on is left
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_state != 3'd0) |=> $stable(mode_latched));

  // R3: JTAG mode parks in startup
  p_jtag_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_state == 3'd1 && is_jtag) |=> (boot_state == 3'd1));

  // R5: idle holds without a rising request edge
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_state == 3'd2 && !ncfg_rise) |=> (boot_state == 3'd2));

  // R6: status high while configuring
  p_status_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_state == 3'd3) |-> nstatus_out);

  // R8: dropped request in configuring or user leads to error
  p_drop_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((boot_state == 3'd3 || boot_state == 3'd4) && !ncfg_in) |=> (boot_state == 3'd5));

  // R9: error keeps status low
  p_err_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_state == 3'd5) |-> !nstatus_out);

  // R10: group 0 pulled down and not up during power-on
  p_pon_pd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_state == 3'd0) |-> (cfg_io_pd_en[0] && !cfg_io_pu_en[0]));

  // R10: configuration pulls released from idle onwards
  p_idle_pulls_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_state == 3'd2) |-> (cfg_io_pd_en == '0 && cfg_io_pu_en == '0));

  // R11: general-purpose pull-ups released in user mode
  p_user_gpio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> (gpio_pu_en == '0));
endmodule

bind cfg_boot_seq cbs_checker #(
  .MODE_W  (MODE_W),
  .N_CFG_IO(N_CFG_IO),
  .N_GPIO  (N_GPIO)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ncfg_in     (ncfg_in),
  .ncfg_rise   (ncfg_rise),
  .is_jtag     (is_jtag),
  .nstatus_out (nstatus_out),
  .user_mode   (user_mode),
  .boot_state  (boot_state),
  .mode_latched(mode_latched),
  .cfg_io_pu_en(cfg_io_pu_en),
  .cfg_io_pd_en(cfg_io_pd_en),
  .gpio_pu_en  (gpio_pu_en)
);

// File: tb/tb_cfg_boot_seq.sv
module tb_cfg_boot_seq;
  localparam int MODE_W   = 3;
  localparam int ERR_HOLD = 16;
  localparam int N_CFG    = 24;
  localparam int N_GP     = 8;
  localparam int JTAG     = 7;

  localparam int S_PON = 0, S_START = 1, S_IDLE = 2, S_CFG = 3, S_USER = 4, S_ERR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_done = 1'b0;
  logic [MODE_W-1:0] mode_sel = '0;
  logic fw_done = 1'b0;
  logic ncfg_in = 1'b1;
  logic cfg_valid = 1'b0, cfg_done = 1'b0, cfg_err = 1'b0;
  logic nstatus_out, cfg_ready, user_mode;
  logic [2:0] boot_state;
  logic [MODE_W-1:0] mode_latched;
  logic [N_CFG-1:0] cfg_io_pu_en, cfg_io_pd_en;
  logic [N_GP-1:0] gpio_pu_en;

  int checks = 0;
  int errors = 0;
  int pd_exp;
  int pu_exp;
  int gp_all;

  always #4 clk = ~clk;

  cfg_boot_seq dut (
    .clk(clk), .rst_n(rst_n), .por_done(por_done), .mode_sel(mode_sel),
    .fw_done(fw_done), .ncfg_in(ncfg_in), .cfg_valid(cfg_valid),
    .cfg_done(cfg_done), .cfg_err(cfg_err), .nstatus_out(nstatus_out),
    .cfg_ready(cfg_ready), .user_mode(user_mode), .boot_state(boot_state),
    .mode_latched(mode_latched), .cfg_io_pu_en(cfg_io_pu_en),
    .cfg_io_pd_en(cfg_io_pd_en), .gpio_pu_en(gpio_pu_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Status expected from the state code, restated from R6/R9.
  function automatic int exp_status(int s);
    return (s == S_CFG || s == S_USER) ? 1 : 0;
  endfunction

  task automatic check_outs(input string req, input int s);
    check({req, " state"}, int'(boot_state), s);
    check({req, " nstatus R6"}, int'(nstatus_out), exp_status(s));
    check({req, " ready R6"}, int'(cfg_ready), (s == S_CFG) ? 1 : 0);
    check({req, " user R7"}, int'(user_mode), (s == S_USER) ? 1 : 0);
    check({req, " pd R10"}, int'(cfg_io_pd_en), (s <= S_START) ? pd_exp : 0);
    check({req, " pu R10"}, int'(cfg_io_pu_en), (s <= S_START) ? pu_exp : 0);
    check({req, " gpio R11"}, int'(gpio_pu_en), (s == S_PON || s == S_USER) ? 0 : gp_all);
  endtask

  task automatic power_up(input int mode);
    rst_n = 1'b0; por_done = 1'b0; fw_done = 1'b0; ncfg_in = 1'b1;
    cfg_valid = 1'b0; cfg_done = 1'b0; cfg_err = 1'b0;
    mode_sel = MODE_W'(mode);
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check_outs("R1 reset", S_PON);
    por_done = 1'b1;
    tick(1);
    check_outs("R1 por", S_START);
    check("R2 latch", int'(mode_latched), mode);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n_err;
    pd_exp = 0;
    for (int i = 0; i < N_CFG; i++)
      if ((i % 8) == 0 && (i / 8) < 3) pd_exp |= (1 << i);
    pu_exp = ((1 << N_CFG) - 1) & ~pd_exp;
    gp_all = (1 << N_GP) - 1;

    // R1: reset state and wait for supplies
    tick(2);
    check_outs("R1 in reset", S_PON);
    rst_n = 1'b1;
    mode_sel = 3'd5;
    tick(3);
    check_outs("R1 no por", S_PON);
    por_done = 1'b1;
    tick(1);
    check_outs("R1 startup", S_START);
    check("R2 captured", int'(mode_latched), 5);
    mode_sel = 3'd7;
    tick(2);
    check("R2 held", int'(mode_latched), 5);
    check_outs("R4 no fw", S_START);

    // R4, R5: request already high on entry to idle starts nothing
    fw_done = 1'b1;
    tick(1);
    fw_done = 1'b0;
    check_outs("R4 idle", S_IDLE);
    tick(3);
    check_outs("R5 level high", S_IDLE);
    ncfg_in = 1'b0;
    tick(1);
    check_outs("R5 low", S_IDLE);
    ncfg_in = 1'b1;
    tick(1);
    check_outs("R5 rise", S_CFG);

    // R7: flags ignored without valid, then clean done
    cfg_done = 1'b1; cfg_err = 1'b1;
    tick(2);
    check_outs("R7 no valid", S_CFG);
    cfg_err = 1'b0; cfg_valid = 1'b1;
    tick(1);
    cfg_valid = 1'b0; cfg_done = 1'b0;
    check_outs("R7 done", S_USER);
    tick(2);
    check_outs("R7 user hold", S_USER);

    // R8, R9: drop in user, full error hold with request low
    ncfg_in = 1'b0;
    tick(1);
    check_outs("R8 user drop", S_ERR);
    n_err = 1;
    for (int k = 0; k < 3 * ERR_HOLD && boot_state == 3'(S_ERR); k++) begin
      tick(1);
      if (boot_state == 3'(S_ERR)) n_err++;
    end
    check("R9 hold length", n_err, ERR_HOLD);
    check_outs("R9 back idle", S_IDLE);

    // R7: error wins over done
    ncfg_in = 1'b1;
    tick(1);
    check_outs("R5 rise2", S_CFG);
    cfg_valid = 1'b1; cfg_done = 1'b1; cfg_err = 1'b1;
    tick(1);
    cfg_valid = 1'b0; cfg_done = 1'b0; cfg_err = 1'b0;
    check_outs("R7 err", S_ERR);
    tick(3);
    check_outs("R9 err hold", S_ERR);
    // R9: falling request leaves error early
    ncfg_in = 1'b0;
    tick(1);
    check_outs("R9 early exit", S_IDLE);

    // R8: drop while configuring
    ncfg_in = 1'b1;
    tick(1);
    check_outs("R5 rise3", S_CFG);
    ncfg_in = 1'b0;
    tick(1);
    check_outs("R8 cfg drop", S_ERR);
    tick(ERR_HOLD);
    check_outs("R9 timeout", S_IDLE);

    // R3: JTAG parks in startup
    power_up(JTAG);
    fw_done = 1'b1;
    for (int k = 0; k < 6; k++) begin
      ncfg_in = ~ncfg_in;
      tick(1);
      check_outs("R3 park", S_START);
    end
    fw_done = 1'b0;

    // R2, R3, R4: sweep every boot mode
    for (int m = 0; m < 8; m++) begin
      power_up(m);
      mode_sel = ~MODE_W'(m);
      fw_done = 1'b1;
      tick(1);
      fw_done = 1'b0;
      check_outs("R4 sweep", (m == JTAG) ? S_START : S_IDLE);
      check("R2 sweep held", int'(mode_latched), m);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule